// File: doc/BRIEF.md
# Sector Transfer Termination Tracker

This block follows a single- or multi-sector data transfer, one byte at a time, and decides when the transfer stops and how that stop is reported. Each byte that moves between the FIFO and the media side is marked by a strobe. A byte counter wraps once per sector, and a sector counter steps from the starting sector number up toward the end-of-track sector.

A transfer can stop for one of four reasons: an acknowledged terminal count, the last byte of the end-of-track sector, the host walking away mid-sector, or a FIFO underrun/overrun. A stop that lands inside a sector does not cut the sector short. The block raises a pad request for every byte still missing, so the device side can fill the sector with zeros.

For reads, the block pulses the result-phase strobe as soon as the stop is decided. For writes, it holds that pulse until the FIFO has drained, because the last byte only counts once the device side has taken it. The termination code is held from the decision until the next transfer starts.

Top module: `xfer_term_tracker`

## Requirements
- R1: While reset is held and after it is released: active_o=0, result_o=0, pad_req_o=0, status_o=2'b00, sector_o=0.
- R2: A start_i pulse loads sector_o with start_sector_i, clears status_o to 2'b00 and raises active_o from the next cycle on, even if a transfer is already running.
- R3: Every SECTOR_BYTES strobes of byte_done_i move sector_o up by one, as long as the sector just finished is not the last one.
- R4: When the last byte of the sector whose number equals eot_sector_i is strobed and no other stop is present, the transfer ends with status_o=2'b01. result_o is high for exactly one cycle.
- R5: Terminal count acts only when tc_i and dack_i are both high. It ends the transfer with status_o=2'b00, and it wins over the end-of-track stop when both fall on the same byte. tc_i with dack_i low has no effect.
- R6: A stop (host_stop_i, acknowledged terminal count or xrun_i) that arrives with a byte count c not equal to 0 raises pad_req_o for exactly SECTOR_BYTES-c cycles before the end. A stop that comes with a strobe counts that byte first. byte_done_i is ignored while padding. host_stop_i ends with status_o=2'b01.
- R7: xrun_i ends with status_o=2'b10 and has priority over terminal count and the host stop.
- R8: With write_dir_i=1 latched at start, result_o is withheld after the stop until fifo_empty_i is sampled high. active_o stays high until then.
- R9: status_o keeps its value after the end, whatever the other inputs do, until the next start_i.
- R10: A stop that arrives with a byte count of 0 and no strobe ends the transfer at once, without any padding.
- R11: active_o falls on the same clock edge that raises result_o. result_o is never high while active_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse that begins the execution phase |
| write_dir_i | input | 1 | 1 = host-to-device transfer, latched at start |
| start_sector_i | input | SEC_W | First sector number |
| eot_sector_i | input | SEC_W | Last sector number of the track, latched at start |
| byte_done_i | input | 1 | One byte moved on the device side of the FIFO |
| tc_i | input | 1 | Terminal count |
| dack_i | input | 1 | Acknowledge that qualifies tc_i |
| host_stop_i | input | 1 | Host stopped sending or taking data |
| xrun_i | input | 1 | FIFO underrun or overrun |
| fifo_empty_i | input | 1 | FIFO is empty |
| active_o | output | 1 | A transfer is in progress |
| sector_o | output | SEC_W | Current sector number |
| pad_req_o | output | 1 | Fill one zero byte this cycle |
| result_o | output | 1 | One-cycle result-phase entry pulse |
| status_o | output | 2 | 00 normal, 01 implicit stop, 10 underrun/overrun |

## Verification
The collision that matters is a terminal count landing on the very byte that closes the end-of-track sector. Two stop causes are then true in one cycle, and the code must come out as normal. The bench strobes the final byte of a sector whose number equals the end-of-track value with tc_i and dack_i high together, and expects status 00 with no padding. A second pairing drives xrun_i and an acknowledged terminal count in one cycle mid-sector. Here it expects code 10 and a pad run that covers the rest of the sector. The scoreboard checks each result pulse against the code, sector number and pad count it predicted.

// File: rtl/xt_pkg.sv
package xt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_PAD   = 2'd2,
    ST_DRAIN = 2'd3
  } xt_state_e;

  typedef enum logic [1:0] {
    TERM_NORMAL   = 2'b00,
    TERM_IMPLICIT = 2'b01,
    TERM_XRUN     = 2'b10
  } term_code_e;

  typedef struct packed {
    logic xrun;
    logic tc;
    logic host_stop;
    logic eot;
  } stop_src_t;
endpackage

// File: rtl/xt_byte_ctr.sv
module xt_byte_ctr #(
  parameter int SECTOR_BYTES = 512,
  localparam int CW = (SECTOR_BYTES > 2) ? $clog2(SECTOR_BYTES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          zero_o
);
  localparam logic [CW-1:0] LAST = CW'(SECTOR_BYTES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q == LAST) cnt_q <= '0;
    else if (inc_i)                 cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xt_sector_ctr.sv
module xt_sector_ctr #(
  parameter int SEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SEC_W-1:0] start_val_i,
  input  logic [SEC_W-1:0] eot_val_i,
  input  logic             adv_i,
  output logic [SEC_W-1:0] sector_o,
  output logic             at_eot_o
);
  logic [SEC_W-1:0] sec_q, eot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      eot_q <= '0;
    end else if (load_i) begin
      sec_q <= start_val_i;
      eot_q <= eot_val_i;
    end else if (adv_i) begin
      sec_q <= sec_q + 1'b1;
    end
  end

  assign sector_o = sec_q;
  assign at_eot_o = (sec_q == eot_q);
endmodule

// File: rtl/xt_term_arb.sv
module xt_term_arb
  import xt_pkg::*;
(
  input  stop_src_t  src_i,
  output logic       any_o,
  output term_code_e code_o
);
  // priority: xrun > explicit tc > implicit (eot, host stop)
  always_comb begin
    any_o = |src_i;
    if (src_i.xrun)    code_o = TERM_XRUN;
    else if (src_i.tc) code_o = TERM_NORMAL;
    else if (any_o)    code_o = TERM_IMPLICIT;
    else               code_o = TERM_NORMAL;
  end
endmodule

// File: rtl/xfer_term_tracker.sv
module xfer_term_tracker
  import xt_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  parameter int SEC_W        = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_dir_i,
  input  logic [SEC_W-1:0] start_sector_i,
  input  logic [SEC_W-1:0] eot_sector_i,
  input  logic             byte_done_i,
  input  logic             tc_i,
  input  logic             dack_i,
  input  logic             host_stop_i,
  input  logic             xrun_i,
  input  logic             fifo_empty_i,
  output logic             active_o,
  output logic [SEC_W-1:0] sector_o,
  output logic             pad_req_o,
  output logic             result_o,
  output logic [1:0]       status_o
);
  localparam int CW = (SECTOR_BYTES > 2) ? $clog2(SECTOR_BYTES) : 1;

  xt_state_e  state_q, state_d;
  term_code_e status_q, status_d;
  logic       write_q;
  logic       result_q, result_d;

  logic          tc_ack, in_xfer, in_pad, stop_req;
  logic          byte_inc, boundary, sec_adv;
  logic [CW-1:0] byte_cnt;
  logic          byte_last, byte_zero, at_eot;
  stop_src_t     src;
  logic          arb_any;
  term_code_e    arb_code;

  assign tc_ack   = tc_i & dack_i;
  assign in_xfer  = (state_q == ST_XFER);
  assign in_pad   = (state_q == ST_PAD);
  assign stop_req = xrun_i | tc_ack | host_stop_i;
  assign byte_inc = (in_xfer & byte_done_i) | in_pad;
  assign boundary = in_xfer & byte_done_i & byte_last;

  xt_byte_ctr #(.SECTOR_BYTES(SECTOR_BYTES)) u_byte_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .inc_i  (byte_inc),
    .cnt_o  (byte_cnt),
    .last_o (byte_last),
    .zero_o (byte_zero)
  );

  xt_sector_ctr #(.SEC_W(SEC_W)) u_sector_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .start_val_i (start_sector_i),
    .eot_val_i   (eot_sector_i),
    .adv_i       (sec_adv),
    .sector_o    (sector_o),
    .at_eot_o    (at_eot)
  );

  always_comb begin
    src.xrun      = in_xfer & xrun_i;
    src.tc        = in_xfer & tc_ack;
    src.host_stop = in_xfer & host_stop_i;
    src.eot       = boundary & at_eot;
  end

  xt_term_arb u_term_arb (
    .src_i  (src),
    .any_o  (arb_any),
    .code_o (arb_code)
  );

  assign sec_adv = boundary & ~arb_any;

  always_comb begin
    logic end_now;
    end_now  = 1'b0;
    state_d  = state_q;
    status_d = status_q;
    result_d = 1'b0;
    unique case (state_q)
      ST_XFER: begin
        if (boundary && arb_any) begin
          end_now  = 1'b1;
          status_d = arb_code;
        end else if (!boundary && stop_req) begin
          status_d = arb_code;
          // stop with a strobe counts that byte, so the sector is partial
          if (byte_done_i || !byte_zero) state_d = ST_PAD;
          else                           end_now = 1'b1;
        end
      end
      ST_PAD:   if (byte_last) end_now = 1'b1;
      ST_DRAIN: if (fifo_empty_i) begin
        state_d  = ST_IDLE;
        result_d = 1'b1;
      end
      default: ;
    endcase
    if (end_now) begin
      if (write_q) state_d = ST_DRAIN;
      else begin
        state_d  = ST_IDLE;
        result_d = 1'b1;
      end
    end
    if (start_i) begin
      state_d  = ST_XFER;
      status_d = TERM_NORMAL;
      result_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      status_q <= TERM_NORMAL;
      write_q  <= 1'b0;
      result_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      result_q <= result_d;
      if (start_i) write_q <= write_dir_i;
    end
  end

  assign active_o  = (state_q != ST_IDLE);
  assign pad_req_o = in_pad;
  assign result_o  = result_q;
  assign status_o  = status_q;
endmodule

// File: rtl/xt_chk.sv
module xt_chk #(
  parameter int SECTOR_BYTES = 512,
  parameter int SEC_W        = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [SEC_W-1:0] start_sector_i,
  input logic             active_o,
  input logic [SEC_W-1:0] sector_o,
  input logic             pad_req_o,
  input logic             result_o,
  input logic [1:0]       status_o
);
  localparam int PW = $clog2(SECTOR_BYTES + 1) + 1;

  logic [PW-1:0] pad_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pad_run <= '0;
    else if (pad_req_o) pad_run <= pad_run + 1'b1;
    else                pad_run <= '0;
  end

  p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_o && status_o == 2'b00 && sector_o == $past(start_sector_i)));

  p_sector_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (sector_o == $past(sector_o) || sector_o == $past(sector_o) + 1'b1));

  p_result_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o |=> !result_o);

  p_pad_bounded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_req_o |-> (active_o && pad_run < PW'(SECTOR_BYTES)));

  p_status_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'b11);

  p_status_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> $stable(status_o));

  p_result_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o |-> !active_o);
endmodule

bind xfer_term_tracker xt_chk #(
  .SECTOR_BYTES (SECTOR_BYTES),
  .SEC_W        (SEC_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .start_sector_i (start_sector_i),
  .active_o       (active_o),
  .sector_o       (sector_o),
  .pad_req_o      (pad_req_o),
  .result_o       (result_o),
  .status_o       (status_o)
);

// File: tb/xfer_term_tracker_tb.sv
`timescale 1ns/1ps
module xfer_term_tracker_tb;
  localparam int SB = 8;
  localparam int SW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 0, write_dir_i = 0, byte_done_i = 0;
  logic          tc_i = 0, dack_i = 0, host_stop_i = 0, xrun_i = 0, fifo_empty_i = 0;
  logic [SW-1:0] start_sector_i = '0, eot_sector_i = '0;
  logic          active_o, pad_req_o, result_o;
  logic [SW-1:0] sector_o;
  logic [1:0]    status_o;

  always #2 clk_i = ~clk_i;

  xfer_term_tracker #(.SECTOR_BYTES(SB), .SEC_W(SW)) u_dut (.*);

  typedef struct {int status; int sector; int pads;} exp_t;
  exp_t exp_q[$];
  int   n_total = 0, n_fail = 0, pad_seen = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_start(input int s, input int e, input bit wr);
    start_sector_i = SW'(s);
    eot_sector_i   = SW'(e);
    write_dir_i    = wr;
    start_i        = 1'b1;
    tick();
    start_i = 1'b0;
  endtask

  // n strobes; acknowledged or bare tc on the last one when requested
  task automatic send_bytes(input int n, input bit tc_last, input bit ack_last);
    for (int i = 0; i < n; i++) begin
      byte_done_i = 1'b1;
      tc_i   = tc_last  && (i == n - 1);
      dack_i = ack_last && (i == n - 1);
      tick();
    end
    byte_done_i = 0;
    tc_i = 0;
    dack_i = 0;
  endtask

  task automatic expect_end(input int st, input int sec, input int pads);
    exp_t e;
    e.status = st; e.sector = sec; e.pads = pads;
    exp_q.push_back(e);
  endtask

  // monitor: scoreboard of result pulses
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (start_i) pad_seen = 0;
      if (pad_req_o) pad_seen++;
      if (result_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected result", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(int'(status_o) == e.status, "R5/R7 status at end", int'(status_o), e.status);
          chk(int'(sector_o) == e.sector, "R3 sector at end", int'(sector_o), e.sector);
          chk(pad_seen == e.pads, "R6 pad count", pad_seen, e.pads);
          chk(!active_o, "R11 active low at result", int'(active_o), 0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chk(!active_o && !result_o && !pad_req_o, "R1 idle in reset", int'(active_o), 0);
    chk(status_o == 2'b00 && sector_o == '0, "R1 status/sector in reset", int'(status_o), 0);
    rst_ni = 1'b1;
    tick();
    chk(!active_o && status_o == 2'b00, "R1 idle after reset", int'(active_o), 0);

    // R2, R3, R4: read across three sectors, stop at eot
    do_start(3, 5, 1'b0);
    chk(active_o == 1'b1, "R2 active after start", int'(active_o), 1);
    chk(int'(sector_o) == 3, "R2 start sector", int'(sector_o), 3);
    expect_end(1, 5, 0);
    send_bytes(SB, 0, 0);
    chk(int'(sector_o) == 4, "R3 sector advance", int'(sector_o), 4);
    send_bytes(SB, 0, 0);
    chk(int'(sector_o) == 5 && active_o, "R3 second advance", int'(sector_o), 5);
    send_bytes(SB, 0, 0);
    chk(!active_o, "R4 ended at eot", int'(active_o), 0);
    repeat (4) tick();

    // R6: host stop mid-sector at count 5, strobes during pad ignored
    do_start(1, 9, 1'b0);
    send_bytes(5, 0, 0);
    expect_end(1, 1, SB - 5);
    host_stop_i = 1'b1;
    tick();
    host_stop_i = 1'b0;
    chk(pad_req_o == 1'b1, "R6 pad starts", int'(pad_req_o), 1);
    byte_done_i = 1'b1;
    repeat (SB - 5) tick();
    byte_done_i = 1'b0;
    chk(!active_o && !pad_req_o, "R6 pad done", int'(pad_req_o), 0);
    repeat (4) tick();

    // R5: tc without dack ignored, tc with dack ends normally
    do_start(2, 9, 1'b0);
    send_bytes(SB, 1, 0);
    chk(active_o && int'(sector_o) == 3, "R5 unqualified tc ignored", int'(sector_o), 3);
    expect_end(0, 3, 0);
    send_bytes(SB, 1, 1);
    repeat (4) tick();

    // R5: tc on last byte of eot sector -> normal
    do_start(4, 4, 1'b0);
    expect_end(0, 4, 0);
    send_bytes(SB, 1, 1);
    repeat (4) tick();

    // R7: xrun and tc together mid-sector at count 2
    do_start(7, 9, 1'b0);
    send_bytes(2, 0, 0);
    expect_end(2, 7, SB - 2);
    xrun_i = 1; tc_i = 1; dack_i = 1;
    tick();
    xrun_i = 0; tc_i = 0; dack_i = 0;
    repeat (SB + 2) tick();

    // R10: stop at byte count zero ends at once
    do_start(6, 9, 1'b0);
    send_bytes(SB, 0, 0);
    expect_end(1, 7, 0);
    host_stop_i = 1'b1;
    tick();
    host_stop_i = 1'b0;
    chk(!pad_req_o && !active_o, "R10 no pad at count zero", int'(pad_req_o), 0);
    repeat (4) tick();

    // R8: write waits for fifo empty
    do_start(1, 1, 1'b1);
    send_bytes(SB, 0, 0);
    repeat (3) tick();
    chk(active_o && !result_o, "R8 held until fifo empty", int'(result_o), 0);
    chk(status_o == 2'b01, "R8 status decided", int'(status_o), 1);
    expect_end(1, 1, 0);
    fifo_empty_i = 1'b1;
    tick();
    chk(result_o == 1'b1, "R8 result on fifo empty", int'(result_o), 1);
    tick();

    // R9: status held while idle under stray inputs
    tc_i = 1; dack_i = 1; host_stop_i = 1; xrun_i = 1; byte_done_i = 1;
    repeat (5) tick();
    tc_i = 0; dack_i = 0; host_stop_i = 0; xrun_i = 0; byte_done_i = 0;
    chk(status_o == 2'b01 && !active_o, "R9 status held", int'(status_o), 1);
    do_start(9, 9, 1'b0);
    chk(status_o == 2'b00, "R9 cleared by start", int'(status_o), 0);
    repeat (4) tick();

    chk(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule